// File: doc/BRIEF.md
# Interrupt Status and Summary Logic

This block collects the event pulses raised by the transmit and receive engines of a network controller and turns them into one level-sensitive interrupt line. Each event lands in a sticky status bit. Software clears a status bit by writing 1 to it. A software-written enable mask selects which pending events count. The enabled, pending events are sorted into two groups, "normal" and "abnormal". Each group drives a summary bit held in the status word. The interrupt line is driven only from those two summary bits, each gated by its own mask bit.

The status word also shows the current 3-bit state of the receive process and of the transmit process. These fields come from the engines and cannot be cleared by software. A one-bit select on a small register port chooses between the status word and the mask word for both reads and writes. A synchronous software reset puts both words back to their default values.

Top module: `nic_irq_status`

## Requirements
- R1: After the reset input goes low, or after a cycle with `softRst` high, the status word reads 0xF000_0000, the mask word reads 0xF3FE_0000 and `irqOut` is low. Bits 31:28 of the status word always read 1.
- R2: A pulse on `evtIn` sets the matching status bit at the next clock edge. This holds for event positions 0-14, 26 and 27. Pulses on any other position have no effect.
- R3: A status write with bit n = 1 clears event bit n. A 0 in the written data leaves the bit unchanged. When an event pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: The normal summary (status bit 16) is set one clock after any of these bits is both pending and enabled in the mask: 0, 2, 6, 11 or 14. It is clear otherwise.
- R5: The abnormal summary (status bit 15) is set one clock after any of these bits is both pending and enabled: 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26 or 27. It is clear otherwise.
- R6: `irqOut` equals the value, one clock earlier, of (normal summary AND mask bit 16) OR (abnormal summary AND mask bit 15). Both summaries in that expression are taken from the status and mask values of that earlier cycle.
- R7: Writing 1 to status bit 15 or 16 has no lasting effect. Both summary bits are recomputed on every clock from the events and the mask.
- R8: Status bits 19:17 show `rxState` and bits 22:20 show `txState`, each registered one clock. Status writes never change these fields. Bits 4 of the layout aside, bits 25:23 read 0.
- R9: `regSel` = 0 selects the status word and `regSel` = 1 selects the mask word. The mask word is fully read/write on all 32 bits. A status write does not change the mask, and a mask write does not change the status events.
- R10: `softRst` takes priority over event pulses and register writes in the same cycle. It also clears the process state fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous software reset to default values |
| evtIn | input | 32 | Single-cycle event pulses, one per status bit position |
| rxState | input | 3 | Current receive-process state |
| txState | input | 3 | Current transmit-process state |
| regWr | input | 1 | Write strobe for the selected register |
| regSel | input | 1 | 0 = status word, 1 = mask word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected word (combinational) |
| irqOut | output | 1 | Level interrupt output |

## Verification
The assertions assume the engines' event pulses and the register port are synchronous to `clk` and stable around the rising edge. They also assume that any history they compare against starts only after reset has been released. The bench changes every input at the falling edge and holds all pulses at zero while reset is active. It then sweeps every one of the 32 event positions and all sixteen combinations of the relevant mask bits. It also covers all eight state values and the simultaneous-event/clear and simultaneous-reset cases. After every clock, the bench compares both words and the interrupt line against its arithmetic model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 32;
  localparam int STATE_W = 3;
  localparam int NIS_POS = 16;
  localparam int AIS_POS = 15;
  localparam int RXS_LSB = 17;
  localparam int TXS_LSB = 20;
  // event groups: normal = 0,2,6,11,14 ; abnormal = 1,3,4,5,7,8,9,10,12,13,26,27
  localparam logic [DATA_W-1:0] NORM_BITS = 32'h0000_4845;
  localparam logic [DATA_W-1:0] ABN_BITS = 32'h0C00_37BA;
  localparam logic [DATA_W-1:0] EVT_BITS = NORM_BITS | ABN_BITS;
  localparam logic [DATA_W-1:0] FIXED_ONES = 32'hF000_0000;
  localparam logic [DATA_W-1:0] MASK_RST = 32'hF3FE_0000;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } regSel_e;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic softRst;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         softRst,
  input  logic         regWr,
  input  logic         regSel,
  output ctrlStrobes_t strobes
);
  regSel_e selE;

  always_comb begin
    selE = regSel_e'(regSel);
    strobes.softRst = softRst;
    strobes.wrStatus = regWr && (selE == SEL_STATUS) && !softRst;
    strobes.wrMask = regWr && (selE == SEL_MASK) && !softRst;
  end

  // R9
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrStatus, strobes.wrMask}));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic [DATA_W-1:0] evtStatus,
  input  logic [DATA_W-1:0] maskWord,
  output logic              nisBit,
  output logic              aisBit,
  output logic              irqOut
);
  logic [DATA_W-1:0] enabled;
  logic nisNext, aisNext, irqNext;

  always_comb begin
    enabled = evtStatus & maskWord;
    nisNext = |(enabled & NORM_BITS);
    aisNext = |(enabled & ABN_BITS);
    irqNext = (nisNext && maskWord[NIS_POS]) || (aisNext && maskWord[AIS_POS]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nisBit <= 1'b0;
      aisBit <= 1'b0;
      irqOut <= 1'b0;
    end else if (softRst) begin
      nisBit <= 1'b0;
      aisBit <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      nisBit <= nisNext;
      aisBit <= aisNext;
      irqOut <= irqNext;
    end
  end

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (nisBit || aisBit));
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  evtIn,
  input  logic [STATE_W-1:0] rxState,
  input  logic [STATE_W-1:0] txState,
  input  logic               regSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [DATA_W-1:0] evtQ, maskQ, clrVec, statusWord;
  logic [STATE_W-1:0] rxQ, txQ;
  logic nisBit, aisBit, pastValid;

  assign clrVec = strobes.wrStatus ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ <= '0;
      maskQ <= MASK_RST;
      rxQ <= '0;
      txQ <= '0;
    end else if (strobes.softRst) begin
      evtQ <= '0;
      maskQ <= MASK_RST;
      rxQ <= '0;
      txQ <= '0;
    end else begin
      evtQ <= ((evtQ & ~clrVec) | evtIn) & EVT_BITS;
      if (strobes.wrMask) maskQ <= wrData;
      rxQ <= rxState;
      txQ <= txState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else pastValid <= 1'b1;
  end

  irq_summary i_summary (
    .clk(clk), .rstN(rstN), .softRst(strobes.softRst),
    .evtStatus(evtQ), .maskWord(maskQ),
    .nisBit(nisBit), .aisBit(aisBit), .irqOut(irqOut)
  );

  always_comb begin
    statusWord = FIXED_ONES | evtQ;
    statusWord[NIS_POS] = nisBit;
    statusWord[AIS_POS] = aisBit;
    statusWord[RXS_LSB +: STATE_W] = rxQ;
    statusWord[TXS_LSB +: STATE_W] = txQ;
    rdData = (regSel_e'(regSel) == SEL_MASK) ? maskQ : statusWord;
  end

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(strobes.softRst)) |->
      ((evtQ & $past(evtIn & EVT_BITS)) == $past(evtIn & EVT_BITS)));
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobes.wrStatus)) |->
      ((evtQ & $past(wrData & ~evtIn & EVT_BITS)) == '0));
  // R3
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!strobes.wrStatus && !strobes.softRst && evtIn == '0)) |->
      $stable(evtQ));
  // R10
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobes.softRst)) |->
      (maskQ == MASK_RST && evtQ == '0 && !irqOut));
  // R8
  state_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(strobes.softRst)) |->
      (rxQ == $past(rxState) && txQ == $past(txState)));
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic [DATA_W-1:0]  evtIn,
  input  logic [STATE_W-1:0] rxState,
  input  logic [STATE_W-1:0] txState,
  input  logic               regWr,
  input  logic               regSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  ctrlStrobes_t strobes;

  irq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .regWr(regWr), .regSel(regSel), .strobes(strobes)
  );

  irq_status_dp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evtIn(evtIn),
    .rxState(rxState), .txState(txState), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/test_nic_irq_status.sv
module test_nic_irq_status;
  localparam logic [31:0] NORM = (32'd1 << 0) | (32'd1 << 2) | (32'd1 << 6) | (32'd1 << 11) | (32'd1 << 14);
  localparam logic [31:0] ABN = (32'd1 << 1) | (32'd1 << 3) | (32'd1 << 4) | (32'd1 << 5) | (32'd1 << 7) |
                                (32'd1 << 8) | (32'd1 << 9) | (32'd1 << 10) | (32'd1 << 12) | (32'd1 << 13) |
                                (32'd1 << 26) | (32'd1 << 27);
  localparam logic [31:0] EVT = NORM | ABN;

  logic clk = 1'b0, rstN = 1'b0, softRst = 1'b0, regWr = 1'b0, regSel = 1'b0, irqOut;
  logic [31:0] evtIn = '0, wrData = '0, rdData;
  logic [2:0] rxSt = '0, txSt = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] mEvt = '0, mMask = 32'hF3FE_0000;
  logic mNis = 0, mAis = 0, mIrq = 0;
  logic [2:0] mRx = '0, mTx = '0;

  always #5 clk = ~clk;

  nic_irq_status i_nic_irq_status (
    .clk(clk), .rstN(rstN), .softRst(softRst), .evtIn(evtIn),
    .rxState(rxSt), .txState(txSt), .regWr(regWr), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] expStatus;
    expStatus = 32'hF000_0000 | (32'(mTx) << 20) | (32'(mRx) << 17) |
                (32'(mNis) << 16) | (32'(mAis) << 15) | mEvt;
    regSel = 1'b0; #1;
    check(tag, "status", rdData, expStatus);
    regSel = 1'b1; #1;
    check(tag, "mask", rdData, mMask);
    check(tag, "irq", {31'b0, irqOut}, {31'b0, mIrq});
  endtask

  // one clock with the currently driven inputs; model follows the requirements
  task automatic cyc(input string tag);
    logic n, a;
    @(posedge clk);
    n = |(mEvt & mMask & NORM);
    a = |(mEvt & mMask & ABN);
    if (softRst) begin
      mEvt = '0; mMask = 32'hF3FE_0000; mNis = 0; mAis = 0; mIrq = 0; mRx = '0; mTx = '0;
    end else begin
      mIrq = (n & mMask[16]) | (a & mMask[15]);
      mNis = n; mAis = a;
      mEvt = ((mEvt & ~((regWr && !regSel) ? wrData : 32'h0)) | evtIn) & EVT;
      if (regWr && regSel) mMask = wrData;
      mRx = rxSt; mTx = txSt;
    end
    @(negedge clk);
    evtIn = '0; regWr = 1'b0; softRst = 1'b0;
    compare(tag);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, input string tag);
    regWr = 1'b1; regSel = sel; wrData = d;
    cyc(tag);
  endtask

  task automatic pulse(input logic [31:0] e, input string tag);
    evtIn = e;
    cyc(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    // R1: default mask disables every event and both summaries
    pulse(32'h0000_0001, "R1");
    cyc("R1");
    wr(1'b0, 32'hFFFF_FFFF, "R3");
    cyc("R3");

    // R2 R3 R4 R5: every bit position
    for (int i = 0; i < 32; i++) begin
      string tg;
      tg = NORM[i] ? "R4" : (ABN[i] ? "R5" : "R2");
      wr(1'b1, 32'hFFFF_FFFF, "R9");
      pulse(32'd1 << i, "R2");
      cyc(tg);
      cyc("R6");
      wr(1'b0, 32'd1 << i, "R3");
      cyc(tg);
    end

    // R6: mask sweep with one normal and one abnormal event pending
    pulse((32'd1 << 0) | (32'd1 << 27), "R2");
    for (int m = 0; m < 16; m++) begin
      wr(1'b1, (32'(m[0]) << 16) | (32'(m[1]) << 15) | (32'(m[2]) << 0) | (32'(m[3]) << 27), "R9");
      cyc("R6");
      cyc("R6");
    end

    // R3: same-cycle event and clear; zero write leaves bits
    wr(1'b1, 32'hFFFF_FFFF, "R9");
    evtIn = 32'd1 << 6;
    wr(1'b0, 32'd1 << 6, "R3");
    cyc("R3");
    wr(1'b0, 32'h0, "R3");
    cyc("R3");

    // R7: writing 1 to the summary bits
    wr(1'b0, (32'd1 << 16) | (32'd1 << 15), "R7");
    cyc("R7");

    // R9: status write leaves mask; mask write leaves events
    wr(1'b0, 32'h0000_0040, "R9");
    wr(1'b1, 32'h1234_5678, "R9");
    wr(1'b1, 32'hA5A5_0F0F, "R9");

    // R8: all state values, status writes of all ones
    for (int v = 0; v < 8; v++) begin
      rxSt = 3'(v); txSt = 3'(7 - v);
      wr(1'b0, 32'hFFFF_FFFF, "R8");
      cyc("R8");
    end

    // R10: soft reset beats an event and a write in the same cycle
    wr(1'b1, 32'hFFFF_FFFF, "R9");
    pulse(EVT, "R2");
    cyc("R6");
    softRst = 1'b1; evtIn = EVT;
    wr(1'b1, 32'h0000_00FF, "R10");
    cyc("R1");
    rxSt = 3'd5; txSt = 3'd2;
    cyc("R8");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule